// File: doc/BRIEF.md
# USB Pipe Packet Buffer Port

This block holds one packet for a single USB pipe and sits between a CPU-side byte port and the link layer. Its direction is fixed by a configuration input. When the pipe transmits, the CPU writes bytes into the buffer. The packet is handed to the link when the byte count reaches the configured maximum packet size, or earlier when the CPU issues an end-of-write command. The link then pops the bytes in the order they were written.

When the pipe receives, the link pushes bytes and closes the packet. The CPU reads the packet length from a 9-bit field and pops the bytes. When the last byte has been read, the buffer frees itself for the next packet. A buffer-clear command discards whatever the buffer holds, in either direction and in any state.

Zero-length packets are handled apart from data packets. On transmit, the CPU clears the buffer and then issues end-of-write with no data. On receive, an empty packet blocks the buffer until the CPU clears it. An optional auto-clear mode drops empty received packets on arrival. CPU accesses that the current state does not allow are ignored and set a sticky error flag.

Top module: `upb_port`

## Requirements
- R1: After reset the buffer is empty and open for filling. In transmit mode cpu_ready is 1. tx_valid, cpu_rx_len and err_flag are 0.
- R2: In transmit mode, the CPU write that brings the byte count up to cfg_max_pkt commits the packet. From the next cycle, tx_valid is 1, tx_len equals cfg_max_pkt and cpu_ready is 0.
- R3: In transmit mode, cmd_bval commits a short packet. tx_len equals the number of bytes written since the buffer was last empty.
- R4: cmd_bclr followed by cmd_bval, with no data written in between, presents a zero-length packet: tx_valid is 1, tx_len is 0 and tx_last is 1. One tx_pop releases the buffer.
- R5: While tx_valid is 1, tx_data shows the bytes in write order, one byte per tx_pop, and tx_last is 1 on the final byte. After the final pop, the buffer is released: tx_valid is 0 and cpu_ready is 1. cpu_ready is never 1 together with tx_valid or rx_ready.
- R6: In receive mode, rx_end closes the packet. cpu_rx_len (9 bits) then gives its byte count, cpu_ready is 1 and cpu_rd_data shows the bytes in arrival order, one byte per cpu_rd_en.
- R7: Reading the last received byte releases the buffer automatically. rx_ready returns to 1, cpu_ready goes to 0 and cpu_rx_len goes to 0.
- R8: A received zero-length packet (rx_end with no bytes) reports cpu_rx_len 0 and cpu_ready 0. A CPU read is not possible, and rx_ready stays 0 until cmd_bclr.
- R9: With cfg_auto_clr at 1, a received zero-length packet is discarded at once. rx_ready stays 1.
- R10: A CPU write when the buffer is not open for CPU writing, or a CPU read when no received byte is available, changes no buffer state and sets err_flag. err_flag then stays 1 until reset.
- R11: cmd_bclr empties the buffer from any state. The discarded bytes never appear at tx_data or cpu_rd_data.
- R12: In receive mode, a packet that reaches cfg_max_pkt bytes is closed without rx_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dir_tx | input | 1 | 1: transmit pipe, 0: receive pipe; changed only while empty |
| cfg_max_pkt | input | 9 | Maximum packet size, 1 to DEPTH |
| cfg_auto_clr | input | 1 | Drop received zero-length packets automatically |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | 8 | CPU write byte |
| cpu_rd_en | input | 1 | CPU byte read strobe |
| cpu_rd_data | output | 8 | Byte at the read position |
| cmd_bval | input | 1 | End-of-write command |
| cmd_bclr | input | 1 | Buffer-clear command |
| cpu_ready | output | 1 | Buffer accessible by the CPU in the current direction |
| cpu_rx_len | output | 9 | Length of the held received packet |
| err_flag | output | 1 | Sticky illegal-access flag |
| tx_valid | output | 1 | Committed packet waiting for the link |
| tx_len | output | 9 | Length of the committed packet |
| tx_data | output | 8 | Byte at the read position for the link |
| tx_last | output | 1 | Current byte is the final one, or the packet is empty |
| tx_pop | input | 1 | Link consumes one byte, or the empty packet |
| rx_ready | output | 1 | Buffer accepts received bytes |
| rx_wr | input | 1 | Link pushes one byte |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | Link closes the received packet |

## Verification
The hardest case to reach from the ports is a commit that coincides with another event. Examples are the final byte landing on the same edge as an end command, or a buffer-clear arriving on the same edge as a commit or a drain. A second hard case is an empty packet met in each direction under both auto-clear settings. Directed steps set up each of these explicitly. The random phase then runs for thousands of cycles with small maximum sizes, so that the count boundary is hit often, and with independent end and clear strobes, so that these collisions also occur unplanned. A bench model follows every cycle.

// File: rtl/upb_pkg.sv
// Shared types for the pipe packet buffer.
package upb_pkg;
    // Ownership state: FILL = writer side may add bytes, HELD = packet committed for the reader side.
    typedef enum logic {
        BUF_FILL = 1'b0,
        BUF_HELD = 1'b1
    } buf_state_e;
endpackage

// File: rtl/upb_mem.sv
// Byte storage for one packet.
// Assumes: one write and one asynchronous read per cycle; contents are not reset,
// since a byte is only read after it has been written.
module upb_mem #(
    parameter int DEPTH = 256,
    parameter int PTR_W = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] store_q [DEPTH];

    // Write one byte at the fill position.
    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    // Present the byte at the read position.
    always_comb begin
        rdata = store_q[raddr];
    end
endmodule

// File: rtl/upb_ctrl.sv
// Fill/drain control for the pipe packet buffer.
// Handles the byte count, the read position, commit and release, and the sticky error flag.
// Assumes: dir_tx, max_pkt and auto_clr change only while the buffer is empty;
// max_pkt lies in 1..DEPTH.
module upb_ctrl
    import upb_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int LEN_W = 9,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_tx,
    input  logic [LEN_W-1:0] max_pkt,
    input  logic             auto_clr,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic             cmd_end,
    input  logic             cmd_clr,
    input  logic             link_push,
    input  logic             link_end,
    input  logic             link_pop,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_waddr,
    output logic [PTR_W-1:0] mem_raddr,
    output logic             held,
    output logic [LEN_W-1:0] fill_cnt,
    output logic             at_last,
    output logic             err
);
    buf_state_e       state_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] rd_q;
    logic             err_q;

    logic             is_fill;
    logic             wr_req, end_req, rd_req;
    logic             wr_ok, rd_ok;
    logic [LEN_W-1:0] cnt_after;
    logic             commit, drop_empty;
    logic             empty_pop, drained, release_buf;
    logic             bad_wr, bad_rd;

    // Route the requests of the current direction to the writer and reader roles.
    always_comb begin
        is_fill = (state_q == BUF_FILL);
        wr_req  = dir_tx ? cpu_wr  : link_push;
        end_req = dir_tx ? cmd_end : link_end;
        rd_req  = dir_tx ? link_pop : cpu_rd;
    end

    // Decide acceptance, commit, release and illegal CPU accesses for this cycle.
    always_comb begin
        wr_ok       = is_fill && wr_req && (cnt_q < max_pkt);
        cnt_after   = cnt_q + LEN_W'(wr_ok);
        commit      = is_fill && ((wr_ok && (cnt_after == max_pkt)) || end_req);
        drop_empty  = commit && !dir_tx && auto_clr && (cnt_after == '0);
        rd_ok       = !is_fill && rd_req && (cnt_q != '0);
        empty_pop   = !is_fill && dir_tx && link_pop && (cnt_q == '0);
        drained     = rd_ok && ((rd_q + LEN_W'(1)) == cnt_q);
        release_buf = drained || empty_pop;
        bad_wr      = cpu_wr && !(dir_tx && is_fill);
        bad_rd      = cpu_rd && !(!dir_tx && !is_fill && (cnt_q != '0));
    end

    // Advance ownership state, byte count and read position; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_clr) begin
            state_q <= BUF_FILL;
            cnt_q   <= '0;
            rd_q    <= '0;
        end else if (is_fill) begin
            cnt_q <= cnt_after;
            rd_q  <= '0;
            if (commit && !drop_empty) begin
                state_q <= BUF_HELD;
            end
        end else if (release_buf) begin
            state_q <= BUF_FILL;
            cnt_q   <= '0;
            rd_q    <= '0;
        end else if (rd_ok) begin
            rd_q <= rd_q + LEN_W'(1);
        end
    end

    // Hold the error flag once any illegal CPU access is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (bad_wr || bad_rd) begin
            err_q <= 1'b1;
        end
    end

    // Drive storage control and status outputs.
    always_comb begin
        mem_we    = wr_ok && !cmd_clr;
        mem_waddr = cnt_q[PTR_W-1:0];
        mem_raddr = rd_q[PTR_W-1:0];
        held      = (state_q == BUF_HELD);
        fill_cnt  = cnt_q;
        at_last   = ((rd_q + LEN_W'(1)) == cnt_q);
        err       = err_q;
    end
endmodule

// File: rtl/upb_port.sv
// Pipe packet buffer seen through a CPU byte port and a link push/pop handshake.
// cfg_dir_tx selects the direction. The CPU writes and the link pops, or the link pushes
// and the CPU reads.
// Assumes: configuration changes only while the buffer is empty.
module upb_port #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    parameter int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_dir_tx,
    input  logic [LEN_W-1:0] cfg_max_pkt,
    input  logic             cfg_auto_clr,
    input  logic             cpu_wr_en,
    input  logic [DW-1:0]    cpu_wr_data,
    input  logic             cpu_rd_en,
    output logic [DW-1:0]    cpu_rd_data,
    input  logic             cmd_bval,
    input  logic             cmd_bclr,
    output logic             cpu_ready,
    output logic [LEN_W-1:0] cpu_rx_len,
    output logic             err_flag,
    output logic             tx_valid,
    output logic [LEN_W-1:0] tx_len,
    output logic [DW-1:0]    tx_data,
    output logic             tx_last,
    input  logic             tx_pop,
    output logic             rx_ready,
    input  logic             rx_wr,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_end
);
    localparam int PTR_W = $clog2(DEPTH);

    logic             mem_we;
    logic [PTR_W-1:0] mem_waddr, mem_raddr;
    logic [DW-1:0]    mem_wdata, mem_rdata;
    logic             held, at_last, err;
    logic [LEN_W-1:0] fill_cnt;

    // Pick the byte source of the writer role.
    always_comb begin
        mem_wdata = cfg_dir_tx ? cpu_wr_data : rx_data;
    end

    upb_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .PTR_W(PTR_W)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_tx    (cfg_dir_tx),
        .max_pkt   (cfg_max_pkt),
        .auto_clr  (cfg_auto_clr),
        .cpu_wr    (cpu_wr_en),
        .cpu_rd    (cpu_rd_en),
        .cmd_end   (cmd_bval),
        .cmd_clr   (cmd_bclr),
        .link_push (rx_wr),
        .link_end  (rx_end),
        .link_pop  (tx_pop),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_raddr (mem_raddr),
        .held      (held),
        .fill_cnt  (fill_cnt),
        .at_last   (at_last),
        .err       (err)
    );

    upb_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W), .DW(DW)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    // Map internal ownership state onto the CPU and link views.
    always_comb begin
        cpu_ready   = cfg_dir_tx ? !held : (held && (fill_cnt != '0));
        cpu_rx_len  = (!cfg_dir_tx && held) ? fill_cnt : '0;
        cpu_rd_data = mem_rdata;
        err_flag    = err;
        tx_valid    = cfg_dir_tx && held;
        tx_len      = fill_cnt;
        tx_data     = mem_rdata;
        tx_last     = tx_valid && ((fill_cnt == '0) || at_last);
        rx_ready    = !cfg_dir_tx && !held;
    end
endmodule

// File: rtl/upb_port_chk.sv
// Property checker for upb_port, attached through bind.
module upb_port_chk #(
    parameter int DW    = 8,
    parameter int LEN_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_dir_tx,
    input logic [LEN_W-1:0] cfg_max_pkt,
    input logic             cpu_rd_en,
    input logic             cmd_bclr,
    input logic             cpu_ready,
    input logic [LEN_W-1:0] cpu_rx_len,
    input logic             err_flag,
    input logic             tx_valid,
    input logic [LEN_W-1:0] tx_len,
    input logic             rx_ready
);
    p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_len <= cfg_max_pkt));

    p_one_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && (tx_valid || rx_ready)));

    p_empty_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_tx && !rx_ready && (cpu_rx_len == '0) && !cmd_bclr) |=> !rx_ready);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    p_bad_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_tx && cpu_rd_en && !cpu_ready) |=> err_flag);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bclr |=> (!tx_valid && (cpu_rx_len == '0)));
endmodule

bind upb_port upb_port_chk #(.DW(DW), .LEN_W(LEN_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dir_tx  (cfg_dir_tx),
    .cfg_max_pkt (cfg_max_pkt),
    .cpu_rd_en   (cpu_rd_en),
    .cmd_bclr    (cmd_bclr),
    .cpu_ready   (cpu_ready),
    .cpu_rx_len  (cpu_rx_len),
    .err_flag    (err_flag),
    .tx_valid    (tx_valid),
    .tx_len      (tx_len),
    .rx_ready    (rx_ready)
);

// File: tb/upb_port_tb_top.sv
`timescale 1ns/1ps
module upb_port_tb_top;
    localparam int DEPTH = 256;
    localparam int LEN_W = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_dir_tx = 1'b1;
    logic [LEN_W-1:0] cfg_max_pkt = 9'd4;
    logic             cfg_auto_clr = 1'b0;
    logic             cpu_wr_en = 1'b0, cpu_rd_en = 1'b0, cmd_bval = 1'b0, cmd_bclr = 1'b0;
    logic [7:0]       cpu_wr_data = '0, rx_data = '0;
    logic             tx_pop = 1'b0, rx_wr = 1'b0, rx_end = 1'b0;
    logic [7:0]       cpu_rd_data, tx_data;
    logic             cpu_ready, err_flag, tx_valid, tx_last, rx_ready;
    logic [LEN_W-1:0] cpu_rx_len, tx_len;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state.
    bit  m_held;
    int  m_cnt, m_rd;
    bit  m_err;
    byte m_buf [DEPTH];

    always #10 clk = ~clk;

    upb_port #(.DEPTH(DEPTH)) dut_i (.*);

    task automatic chk(input string what, input int act, input int exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int e_ready();
        return cfg_dir_tx ? int'(!m_held) : int'(m_held && m_cnt != 0);
    endfunction

    // Update the model from the requirements, using the state before the edge.
    task automatic model_step(input bit wr, input byte wd, input bit rd, input bit pop,
                              input bit bv, input bit bc, input bit rw, input byte rdd, input bit re);
        bit tx = cfg_dir_tx;
        if ((wr && !(tx && !m_held)) || (rd && !(!tx && m_held && m_cnt != 0))) m_err = 1;
        if (bc) begin
            m_held = 0; m_cnt = 0; m_rd = 0;
        end else if (!m_held) begin
            bit w = tx ? wr : rw;
            bit e = tx ? bv : re;
            bit hit = 0;
            if (w && m_cnt < int'(cfg_max_pkt)) begin
                m_buf[m_cnt] = tx ? wd : rdd;
                m_cnt++;
                hit = (m_cnt == int'(cfg_max_pkt));
            end
            if (hit || e) begin
                if (!(!tx && cfg_auto_clr && m_cnt == 0)) begin
                    m_held = 1; m_rd = 0;
                end
            end
        end else begin
            bit r = tx ? pop : rd;
            if (m_cnt == 0) begin
                if (tx && pop) begin m_held = 0; end
            end else if (r) begin
                m_rd++;
                if (m_rd == m_cnt) begin m_held = 0; m_cnt = 0; m_rd = 0; end
            end
        end
    endtask

    task automatic compare_all(input string req);
        chk("cpu_ready", int'(cpu_ready), e_ready(), req);
        chk("tx_valid", int'(tx_valid), int'(cfg_dir_tx && m_held), req);
        chk("rx_ready", int'(rx_ready), int'(!cfg_dir_tx && !m_held), req);
        chk("cpu_rx_len", int'(cpu_rx_len), (!cfg_dir_tx && m_held) ? m_cnt : 0, req);
        chk("err_flag", int'(err_flag), int'(m_err), req);
        if (cfg_dir_tx && m_held) begin
            chk("tx_len", int'(tx_len), m_cnt, req);
            chk("tx_last", int'(tx_last), int'(m_cnt == 0 || m_rd + 1 == m_cnt), req);
            if (m_cnt != 0) chk("tx_data", int'(tx_data), int'(m_buf[m_rd]) & 8'hff, req);
        end
        if (!cfg_dir_tx && m_held && m_cnt != 0)
            chk("cpu_rd_data", int'(cpu_rd_data), int'(m_buf[m_rd]) & 8'hff, req);
    endtask

    // Apply one cycle of stimulus, step the model, then compare after the edge.
    task automatic cyc(input bit wr, input byte wd, input bit rd, input bit pop, input bit bv,
                       input bit bc, input bit rw, input byte rdd, input bit re, input string req);
        cpu_wr_en = wr; cpu_wr_data = wd; cpu_rd_en = rd; tx_pop = pop;
        cmd_bval = bv; cmd_bclr = bc; rx_wr = rw; rx_data = rdd; rx_end = re;
        model_step(wr, wd, rd, pop, bv, bc, rw, rdd, re);
        @(posedge clk); #2;
        cpu_wr_en = 0; cpu_rd_en = 0; tx_pop = 0; cmd_bval = 0; cmd_bclr = 0; rx_wr = 0; rx_end = 0;
        compare_all(req);
    endtask

    task automatic do_reset();
        rst_n = 0;
        m_held = 0; m_cnt = 0; m_rd = 0; m_err = 0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1;
    endtask

    task automatic cpu_wr(input byte b, input string q);  cyc(1, b, 0, 0, 0, 0, 0, 0, 0, q); endtask
    task automatic cpu_rd(input string q);                cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, q); endtask
    task automatic lk_pop(input string q);                cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, q); endtask
    task automatic bval(input string q);                  cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, q); endtask
    task automatic bclr(input string q);                  cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, q); endtask
    task automatic rx_push(input byte b, input string q); cyc(0, 0, 0, 0, 0, 0, 1, b, 0, q); endtask
    task automatic rx_close(input string q);              cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, q); endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681357));
        do_reset();
        // R1: reset state
        chk("cpu_ready", int'(cpu_ready), 1, "R1");
        chk("tx_valid", int'(tx_valid), 0, "R1");
        chk("cpu_rx_len", int'(cpu_rx_len), 0, "R1");
        chk("err_flag", int'(err_flag), 0, "R1");

        // R2: auto commit at max size 4, then R5 ordered pops
        for (int i = 0; i < 4; i++) cpu_wr(byte'(8'hA0 + i), "R2");
        chk("tx_len", int'(tx_len), 4, "R2");
        chk("cpu_ready", int'(cpu_ready), 0, "R2");
        for (int i = 0; i < 4; i++) begin
            chk("tx_data", int'(tx_data), 8'hA0 + i, "R5");
            lk_pop("R5");
        end
        chk("cpu_ready", int'(cpu_ready), 1, "R5");

        // R3: short packet via end-of-write
        cpu_wr(8'h11, "R3"); cpu_wr(8'h22, "R3"); bval("R3");
        chk("tx_len", int'(tx_len), 2, "R3");
        lk_pop("R5"); lk_pop("R5");

        // R4: zero-length transmit packet
        bclr("R4"); bval("R4");
        chk("tx_valid", int'(tx_valid), 1, "R4");
        chk("tx_last", int'(tx_last), 1, "R4");
        lk_pop("R4");
        chk("cpu_ready", int'(cpu_ready), 1, "R4");

        // R11: clear discards a committed packet
        cpu_wr(8'h33, "R11"); cpu_wr(8'h44, "R11"); bval("R11"); bclr("R11");
        cpu_wr(8'h55, "R11"); bval("R11");
        chk("tx_data", int'(tx_data), 8'h55, "R11");
        // R10: write while held is ignored and flagged
        cpu_wr(8'h66, "R10");
        chk("tx_len", int'(tx_len), 1, "R10");
        chk("err_flag", int'(err_flag), 1, "R10");
        lk_pop("R5");

        // Receive side with a fresh error flag
        do_reset();
        cfg_dir_tx = 0; cfg_max_pkt = 9'd6;
        rx_push(8'h71, "R6"); rx_push(8'h72, "R6"); rx_push(8'h73, "R6"); rx_close("R6");
        chk("cpu_rx_len", int'(cpu_rx_len), 3, "R6");
        for (int i = 0; i < 3; i++) begin
            chk("cpu_rd_data", int'(cpu_rd_data), 8'h71 + i, "R6");
            cpu_rd("R7");
        end
        chk("rx_ready", int'(rx_ready), 1, "R7");
        for (int i = 0; i < 6; i++) rx_push(byte'(i * 7), "R12");
        chk("cpu_rx_len", int'(cpu_rx_len), 6, "R12");
        for (int i = 0; i < 6; i++) cpu_rd("R12");

        // R8: received empty packet blocks until clear
        rx_close("R8");
        chk("cpu_ready", int'(cpu_ready), 0, "R8");
        chk("err_flag", int'(err_flag), 0, "R8");
        cpu_rd("R8");
        chk("err_flag", int'(err_flag), 1, "R8");
        rx_push(8'h99, "R8");
        chk("rx_ready", int'(rx_ready), 0, "R8");
        bclr("R8");
        chk("rx_ready", int'(rx_ready), 1, "R8");

        // R9: auto-clear drops an empty received packet
        cfg_auto_clr = 1;
        rx_close("R9");
        chk("rx_ready", int'(rx_ready), 1, "R9");

        // Random phase over several configurations
        for (int ep = 0; ep < 40; ep++) begin
            int sz;
            bclr("R11");
            cfg_dir_tx = 1'($urandom % 2);
            cfg_auto_clr = 1'($urandom % 2);
            sz = $urandom % 6;
            cfg_max_pkt = (sz == 5) ? 9'd16 : 9'(sz + 1);
            for (int c = 0; c < 120; c++) begin
                cyc(1'($urandom % 3 == 0), byte'($urandom), 1'($urandom % 3 == 0),
                    1'($urandom % 2), 1'($urandom % 10 == 0), 1'($urandom % 40 == 0),
                    1'($urandom % 2), byte'($urandom), 1'($urandom % 10 == 0), "R10");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule